// File: doc/BRIEF.md
# Paced UART Transmitter

This block is the sending half of a byte-wide asynchronous serial port. A host writes bytes into a small register window. Each byte waits in a single holding byte or, when queueing is switched on, in a first-in first-out queue. It is then moved into a shift engine that sends a start bit, the data bits least-significant first, an optional parity bit and one or two stop bits on `serial_out`. How long a character takes follows from the frame length and the divisor. A queued byte enters the shift engine on the same clock edge at which the previous stop bit ends, so consecutive characters are spaced by exactly one character time.

The shift engine is a state machine with the states TX_IDLE, TX_START, TX_DATA, TX_PARITY and TX_STOP. Its transitions are:

- TX_IDLE to TX_START on a load.
- TX_START to TX_DATA when a bit time ends.
- TX_DATA to TX_PARITY, or to TX_STOP when parity is off, when the last data bit ends.
- TX_PARITY to TX_STOP when its bit time ends.
- TX_STOP to TX_STOP between two stop bits.
- TX_STOP to TX_START when the last stop bit ends and a byte is waiting.
- TX_STOP to TX_IDLE when the last stop bit ends and nothing is waiting.

The host watches three flags:

- `thre` says whether the holding stage can take more data.
- `temt` says whether the transmitter has gone fully quiet.
- `txe_pend` is a sticky flag that is raised when the transmitter runs dry.

In loopback mode each byte is handed to the receiver through `lb_valid`/`lb_data` and the line stays at mark.

Top module: `uart_tx_pacer`

## Requirements
- R1: After reset:
  - `divisor` is 12, `line_ctl` is 0x00 and `modem_ctl` is 0x08.
  - `thre` and `temt` are 1 and `txe_pend` is 0.
  - `serial_out` is 1.
- R2: Writes decode `wr_addr` as follows. When `line_ctl[7]` is set, address 0 writes the low divisor byte, address 1 writes the high divisor byte, and neither write sends anything. When `line_ctl[7]` is clear, address 0 is the transmit data, and a write to address 1 has no effect on any output. Address 2 is queue control: bit 0 enables the queue and bit 2 flushes it. Address 3 is line control. Address 4 writes modem control, of which the low 5 bits are kept.
- R3: `divisor` takes the 16-bit value {high, low} after each divisor-byte write unless that value is zero, in which case it keeps its previous value. The bit clock ticks once every `divisor`×UNIT_CLKS clocks, and every bit lasts 16 ticks.
- R4: The frame is built from `line_ctl` as follows. Between frames the line idles at 1.
  - A start bit of 0.
  - 5+`line_ctl[1:0]` data bits, least-significant first. Data bits above that width are dropped.
  - A parity bit when `line_ctl[3]` is 1.
  - Stop bits of 1: two when `line_ctl[2]` is 1, otherwise one.
- R5: The parity bit makes the total count of ones in data plus parity even when `line_ctl[4]` is 1, and odd when it is 0.
- R6: A transmit-data write clears `thre`, `temt` and `txe_pend` on the next cycle.
- R7: With the queue off, one byte is held. A write made while that byte is still waiting replaces it. `thre` returns to 1 when the held byte moves into the shift engine, one cycle after the write if the engine is idle.
- R8: With the queue on, it stores up to FIFO_DEPTH bytes in write order. A write while the queue is full is dropped. `thre` returns to 1 when the last queued byte enters the shift engine. Consecutive characters start exactly 16×(frame bits)×`divisor`×UNIT_CLKS clocks apart.
- R9: When the last stop bit ends with nothing waiting, `temt` and `txe_pend` rise together. `txe_pend` then holds until the next transmit-data write.
- R10: A queue-control write with bit 2 set, or one that changes the enable bit, empties the queue and the holding byte and sets `thre`. A character already on the line completes.
- R11: While `modem_ctl[4]` is 1:
  - `serial_out` stays 1.
  - Every byte that enters the shift engine gives a one-cycle `lb_valid` on the next cycle.
  - `lb_data` carries that byte masked to the data width.
- R12: While `line_ctl[6]` is 1 and loopback is off, `serial_out` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address |
| wr_data | input | 8 | Register write data |
| serial_out | output | 1 | Serial line, idle high |
| lb_valid | output | 1 | Loopback byte strobe to the receiver |
| lb_data | output | 8 | Loopback byte |
| thre | output | 1 | Holding stage empty |
| temt | output | 1 | Transmitter fully empty |
| txe_pend | output | 1 | Sticky transmit-empty pending flag |
| divisor | output | 16 | Divisor in effect |
| line_ctl | output | 8 | Line control register |
| modem_ctl | output | 5 | Modem control register |

## Verification
The timing checked for each stimulus is as follows:

- Status flags respond on the cycle after a register write.
- An idle engine pulls the line low one cycle after a data write.
- `lb_valid` appears one cycle after the load.
- `temt` rises exactly 16×(frame bits)×`divisor` clocks after the load.

The bench drives on falling edges and samples on falling edges, counting edges from the write to the expected cycle. It also checks the cycle before, so an early or late flag is caught. Received frames are decoded in the middle of each bit, timed from the first low sample. Character spacing is measured between the start-bit edges of consecutive frames.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;

    typedef enum logic [2:0] {
        TX_IDLE,
        TX_START,
        TX_DATA,
        TX_PARITY,
        TX_STOP
    } tx_state_e;

    // register window
    localparam logic [2:0] A_DATA  = 3'd0;
    localparam logic [2:0] A_DIVHI = 3'd1;
    localparam logic [2:0] A_QCTL  = 3'd2;
    localparam logic [2:0] A_LCTL  = 3'd3;
    localparam logic [2:0] A_MCTL  = 3'd4;

    localparam int          BIT_TICKS  = 16;
    localparam logic [15:0] DIV_RESET  = 16'd12;
    localparam logic [4:0]  MCTL_RESET = 5'h08;

    typedef struct packed {
        logic [2:0] nbits_m1;
        logic       par_en;
        logic       par_even;
        logic       two_stop;
    } frame_cfg_t;

endpackage

// File: rtl/uart_tx_baud.sv
module uart_tx_baud #(
    parameter int UNIT_CLKS = 1
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [15:0] div,
    output logic        tick
);
    localparam int CW = 16 + $clog2(UNIT_CLKS + 1);

    logic [CW-1:0] cnt;
    logic [CW-1:0] period;

    assign period = CW'(div) * CW'(UNIT_CLKS);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt  <= '0;
            tick <= 1'b0;
        end else if (cnt >= period - CW'(1)) begin
            cnt  <= '0;
            tick <= 1'b1;
        end else begin
            cnt  <= cnt + CW'(1);
            tick <= 1'b0;
        end
    end
endmodule

// File: rtl/uart_tx_fifo.sv
module uart_tx_fifo #(
    parameter int DEPTH = 16,
    parameter int W     = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       flush,
    input  logic                       push,
    input  logic [W-1:0]               din,
    input  logic                       pop,
    output logic [W-1:0]               dout,
    output logic [$clog2(DEPTH+1)-1:0] count
);
    localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNTW = $clog2(DEPTH + 1);

    logic [W-1:0]  mem [DEPTH];
    logic [PW-1:0] wp, rp;
    logic          push_ok, pop_ok;

    assign push_ok = push && (count < CNTW'(DEPTH));
    assign pop_ok  = pop && (count != '0);
    assign dout    = mem[rp];

    function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
    endfunction

    always_ff @(posedge clk) begin
        if (push_ok && !flush) mem[wp] <= din;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wp    <= '0;
            rp    <= '0;
            count <= '0;
        end else if (flush) begin
            wp    <= '0;
            rp    <= '0;
            count <= '0;
        end else begin
            if (push_ok) wp <= bump(wp);
            if (pop_ok)  rp <= bump(rp);
            count <= count + CNTW'(push_ok) - CNTW'(pop_ok);
        end
    end
endmodule

// File: rtl/uart_tx_shifter.sv
module uart_tx_shifter
    import uart_tx_pkg::*;
#(
    parameter int TICKS = BIT_TICKS
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic       load,
    input  logic [7:0] load_data,
    input  frame_cfg_t cfg,
    output logic       ready,
    output logic       busy,
    output logic       done,
    output logic       txd
);
    localparam int SW = $clog2(TICKS);

    tx_state_e  st, st_nx;
    logic [SW-1:0] sub;
    logic [2:0]    bidx;
    logic          sidx;
    logic [7:0]    sh;
    logic          pbit;
    frame_cfg_t    cfg_q;
    logic          bit_end, last;

    assign bit_end = tick && (sub == SW'(TICKS - 1));
    assign last    = (st == TX_STOP) && bit_end && (sidx == cfg_q.two_stop);
    assign ready   = (st == TX_IDLE) || last;
    assign busy    = (st != TX_IDLE);
    assign done    = last;

    always_comb begin
        st_nx = st;
        unique case (st)
            TX_IDLE:   if (load) st_nx = TX_START;
            TX_START:  if (bit_end) st_nx = TX_DATA;
            TX_DATA:   if (bit_end && bidx == cfg_q.nbits_m1)
                           st_nx = cfg_q.par_en ? TX_PARITY : TX_STOP;
            TX_PARITY: if (bit_end) st_nx = TX_STOP;
            TX_STOP:   if (last) st_nx = load ? TX_START : TX_IDLE;
            default:   st_nx = TX_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= TX_IDLE;
        else        st <= st_nx;
    end

    // datapath counters and shift register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sub   <= '0;
            bidx  <= '0;
            sidx  <= 1'b0;
            sh    <= '0;
            pbit  <= 1'b0;
            cfg_q <= '0;
        end else if (load) begin
            sub   <= '0;
            bidx  <= '0;
            sidx  <= 1'b0;
            sh    <= load_data;
            cfg_q <= cfg;
            pbit  <= cfg.par_even ? ^load_data : ~^load_data;
        end else if (tick) begin
            sub <= bit_end ? '0 : sub + SW'(1);
            if (bit_end && st == TX_DATA) begin
                sh   <= sh >> 1;
                bidx <= bidx + 3'd1;
            end
            if (bit_end && st == TX_STOP) sidx <= 1'b1;
        end
    end

    // line output
    always_comb begin
        unique case (st)
            TX_START:  txd = 1'b0;
            TX_DATA:   txd = sh[0];
            TX_PARITY: txd = pbit;
            default:   txd = 1'b1;
        endcase
    end
endmodule

// File: rtl/uart_tx_pacer.sv
module uart_tx_pacer
    import uart_tx_pkg::*;
#(
    parameter int FIFO_DEPTH = 16,
    parameter int UNIT_CLKS  = 1
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic [2:0]  wr_addr,
    input  logic [7:0]  wr_data,
    output logic        serial_out,
    output logic        lb_valid,
    output logic [7:0]  lb_data,
    output logic        thre,
    output logic        temt,
    output logic        txe_pend,
    output logic [15:0] divisor,
    output logic [7:0]  line_ctl,
    output logic [4:0]  modem_ctl
);
    localparam int CNTW = $clog2(FIFO_DEPTH + 1);

    logic [7:0]      dll, dlm, thr, dmask, ld_byte;
    logic            fifo_en, thr_full;
    logic            data_wr, dll_wr, dlm_wr, qctl_wr, lctl_wr, mctl_wr, flush;
    logic [15:0]     div_cand;
    logic            tick, sh_ready, sh_busy, sh_done, sh_txd;
    logic            src_has, load, last_out, empty_evt;
    logic [7:0]      fifo_dout;
    logic [CNTW-1:0] fifo_cnt;
    frame_cfg_t      cfg;

    assign data_wr  = wr_en && wr_addr == A_DATA  && !line_ctl[7];
    assign dll_wr   = wr_en && wr_addr == A_DATA  &&  line_ctl[7];
    assign dlm_wr   = wr_en && wr_addr == A_DIVHI &&  line_ctl[7];
    assign qctl_wr  = wr_en && wr_addr == A_QCTL;
    assign lctl_wr  = wr_en && wr_addr == A_LCTL;
    assign mctl_wr  = wr_en && wr_addr == A_MCTL;
    assign div_cand = dll_wr ? {dlm, wr_data} : {wr_data, dll};
    assign flush    = qctl_wr && (wr_data[2] || (wr_data[0] != fifo_en));

    assign dmask    = 8'hFF >> (2'd3 - line_ctl[1:0]);
    assign src_has  = fifo_en ? (fifo_cnt != '0) : thr_full;
    assign ld_byte  = (fifo_en ? fifo_dout : thr) & dmask;
    assign load     = sh_ready && src_has && !flush;
    assign last_out = fifo_en ? (fifo_cnt == CNTW'(1)) : 1'b1;
    assign empty_evt = (sh_done && !load) || (flush && !sh_busy);

    assign cfg.nbits_m1 = 3'd4 + {1'b0, line_ctl[1:0]};
    assign cfg.par_en   = line_ctl[3];
    assign cfg.par_even = line_ctl[4];
    assign cfg.two_stop = line_ctl[2];

    uart_tx_baud #(.UNIT_CLKS(UNIT_CLKS)) u_baud (
        .clk(clk), .rst_n(rst_n), .div(divisor), .tick(tick)
    );

    uart_tx_fifo #(.DEPTH(FIFO_DEPTH), .W(8)) u_fifo (
        .clk(clk), .rst_n(rst_n), .flush(flush),
        .push(data_wr && fifo_en), .din(wr_data),
        .pop(load && fifo_en), .dout(fifo_dout), .count(fifo_cnt)
    );

    uart_tx_shifter #(.TICKS(BIT_TICKS)) u_shift (
        .clk(clk), .rst_n(rst_n), .tick(tick), .load(load),
        .load_data(ld_byte), .cfg(cfg), .ready(sh_ready),
        .busy(sh_busy), .done(sh_done), .txd(sh_txd)
    );

    // control registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            line_ctl  <= '0;
            modem_ctl <= MCTL_RESET;
            dll       <= DIV_RESET[7:0];
            dlm       <= DIV_RESET[15:8];
            divisor   <= DIV_RESET;
            fifo_en   <= 1'b0;
        end else begin
            if (lctl_wr) line_ctl  <= wr_data;
            if (mctl_wr) modem_ctl <= wr_data[4:0];
            if (dll_wr)  dll <= wr_data;
            if (dlm_wr)  dlm <= wr_data;
            if ((dll_wr || dlm_wr) && div_cand != 16'd0) divisor <= div_cand;
            if (qctl_wr) fifo_en <= wr_data[0];
        end
    end

    // holding byte, status flags, loopback strobe
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            thr      <= '0;
            thr_full <= 1'b0;
            thre     <= 1'b1;
            temt     <= 1'b1;
            txe_pend <= 1'b0;
            lb_valid <= 1'b0;
            lb_data  <= '0;
        end else begin
            if (data_wr && !fifo_en) thr <= wr_data;
            if (flush)                    thr_full <= 1'b0;
            else if (data_wr && !fifo_en) thr_full <= 1'b1;
            else if (load && !fifo_en)    thr_full <= 1'b0;

            if (data_wr)                          thre <= 1'b0;
            else if (flush || (load && last_out)) thre <= 1'b1;

            if (data_wr) begin
                temt     <= 1'b0;
                txe_pend <= 1'b0;
            end else if (empty_evt) begin
                temt     <= 1'b1;
                txe_pend <= 1'b1;
            end

            lb_valid <= load && modem_ctl[4];
            if (load) lb_data <= ld_byte;
        end
    end

    always_comb begin
        if (modem_ctl[4])     serial_out = 1'b1;
        else if (line_ctl[6]) serial_out = 1'b0;
        else                  serial_out = sh_txd;
    end
endmodule

// File: rtl/uart_tx_pacer_chk.sv
module uart_tx_pacer_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        wr_en,
    input logic [2:0]  wr_addr,
    input logic [7:0]  line_ctl,
    input logic [4:0]  modem_ctl,
    input logic        thre,
    input logic        temt,
    input logic        txe_pend,
    input logic        lb_valid,
    input logic [15:0] divisor
);
    // R6
    data_wr_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == 3'd0 && !line_ctl[7]) |=> (!thre && !temt && !txe_pend));

    // R9
    temt_after_thre_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(temt) |-> thre);

    // R9
    pend_with_temt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(txe_pend) |-> temt);

    // R3
    divisor_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        divisor != 16'd0);

    // R11
    lb_only_loop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lb_valid) |-> $past(modem_ctl[4]));
endmodule

bind uart_tx_pacer uart_tx_pacer_chk u_chk (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .line_ctl(line_ctl), .modem_ctl(modem_ctl), .thre(thre), .temt(temt),
    .txe_pend(txe_pend), .lb_valid(lb_valid), .divisor(divisor)
);

// File: tb/uart_tx_pacer_tb.sv
module uart_tx_pacer_tb;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [7:0]  wr_data = '0;
    logic        serial_out, lb_valid, thre, temt, txe_pend;
    logic [7:0]  lb_data, line_ctl;
    logic [15:0] divisor;
    logic [4:0]  modem_ctl;

    int n_chk = 0;
    int n_err = 0;
    int cyc = 0;

    uart_tx_pacer u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .serial_out(serial_out), .lb_valid(lb_valid),
        .lb_data(lb_data), .thre(thre), .temt(temt), .txe_pend(txe_pend),
        .divisor(divisor), .line_ctl(line_ctl), .modem_ctl(modem_ctl)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic set_div(input logic [15:0] d, input logic [7:0] lcr);
        wr(3'd3, 8'h80);
        wr(3'd0, d[7:0]);
        wr(3'd1, d[15:8]);
        wr(3'd3, lcr);
    endtask

    task automatic wait_temt();
        while (temt !== 1'b1) @(negedge clk);
        repeat (4) @(negedge clk);
    endtask

    task automatic rx_frame(input int d, input int nb, input bit pe, input bit ts,
                            input int wait_max, output bit got, output logic [7:0] data,
                            output logic pb, output bit stop_ok, output int t0);
        got = 1'b0; data = '0; pb = 1'b0; stop_ok = 1'b0; t0 = 0;
        for (int i = 0; i < wait_max; i++) begin
            @(negedge clk);
            if (serial_out === 1'b0) begin
                got = 1'b1;
                break;
            end
        end
        if (!got) return;
        t0 = cyc;
        repeat (8 * d) @(negedge clk);
        for (int i = 0; i < nb; i++) begin
            repeat (16 * d) @(negedge clk);
            data[i] = serial_out;
        end
        if (pe) begin
            repeat (16 * d) @(negedge clk);
            pb = serial_out;
        end
        stop_ok = 1'b1;
        for (int s = 0; s < (ts ? 2 : 1); s++) begin
            repeat (16 * d) @(negedge clk);
            stop_ok = stop_ok & serial_out;
        end
    endtask

    task automatic t_reset();
        check("R1", "divisor", divisor, 12);
        check("R1", "line_ctl", line_ctl, 0);
        check("R1", "modem_ctl", modem_ctl, 8);
        check("R1", "thre", thre, 1);
        check("R1", "temt", temt, 1);
        check("R1", "txe_pend", txe_pend, 0);
        check("R1", "serial_out", serial_out, 1);
    endtask

    task automatic t_regs();
        int lows = 0;
        set_div(16'd1, 8'h03);
        check("R2", "divisor after DLAB writes", divisor, 1);
        check("R2", "line_ctl", line_ctl, 3);
        check("R2", "thre after DLAB data-offset write", thre, 1);
        wr(3'd1, 8'hFF);
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            if (serial_out !== 1'b1) lows++;
        end
        check("R2", "offset 1 without DLAB: divisor", divisor, 1);
        check("R2", "offset 1 without DLAB: line lows", lows, 0);
        check("R2", "offset 1 without DLAB: thre", thre, 1);
        wr(3'd4, 8'hE7);
        check("R2", "modem_ctl 5-bit", modem_ctl, 5'h07);
        wr(3'd4, 8'h08);
    endtask

    task automatic t_format();
        bit got, sok; logic [7:0] d; logic pb; int t0;
        fork
            wr(3'd0, 8'hA5);
            rx_frame(1, 8, 0, 0, 50, got, d, pb, sok, t0);
        join
        check("R4", "8N1 frame seen", got, 1);
        check("R4", "8N1 data", d, 8'hA5);
        check("R4", "8N1 stop", sok, 1);
        wait_temt();
        wr(3'd3, 8'h04);
        fork
            wr(3'd0, 8'hF3);
            rx_frame(1, 5, 0, 1, 50, got, d, pb, sok, t0);
        join
        check("R4", "5-bit masked data", d, 8'h13);
        check("R4", "two stop bits", sok, 1);
        wait_temt();
    endtask

    task automatic t_parity();
        bit got, sok; logic [7:0] d; logic pb; int t0;
        wr(3'd3, 8'h1A);
        fork
            wr(3'd0, 8'h07);
            rx_frame(1, 7, 1, 0, 50, got, d, pb, sok, t0);
        join
        check("R5", "7E1 data", d, 8'h07);
        check("R5", "even parity of 0x07", pb, 1);
        wait_temt();
        wr(3'd3, 8'h0A);
        fork
            wr(3'd0, 8'h07);
            rx_frame(1, 7, 1, 0, 50, got, d, pb, sok, t0);
        join
        check("R5", "odd parity of 0x07", pb, 0);
        wait_temt();
        fork
            wr(3'd0, 8'h55);
            rx_frame(1, 7, 1, 0, 50, got, d, pb, sok, t0);
        join
        check("R5", "odd parity of 0x55", pb, 1);
        wait_temt();
        wr(3'd3, 8'h03);
    endtask

    task automatic t_status();
        wr(3'd0, 8'h3C);
        check("R6", "thre after write", thre, 0);
        check("R6", "temt after write", temt, 0);
        check("R6", "pend after write", txe_pend, 0);
        @(negedge clk);
        check("R7", "thre once loaded", thre, 1);
        repeat (159) @(negedge clk);
        check("R9", "temt before frame end", temt, 0);
        @(negedge clk);
        check("R9", "temt at frame end", temt, 1);
        check("R9", "pend at frame end", txe_pend, 1);
        repeat (20) @(negedge clk);
        check("R9", "pend held", txe_pend, 1);
        wr(3'd0, 8'h00);
        check("R6", "pend cleared by write", txe_pend, 0);
        wait_temt();
    endtask

    task automatic t_overwrite();
        bit got, sok; logic [7:0] d; logic pb; int t0;
        fork
            begin
                wr(3'd0, 8'h41);
                wr(3'd0, 8'h42);
                wr(3'd0, 8'h43);
            end
            rx_frame(1, 8, 0, 0, 50, got, d, pb, sok, t0);
        join
        check("R7", "first byte", d, 8'h41);
        rx_frame(1, 8, 0, 0, 50, got, d, pb, sok, t0);
        check("R7", "replacing byte", d, 8'h43);
        rx_frame(1, 8, 0, 0, 200, got, d, pb, sok, t0);
        check("R7", "no third frame", got, 0);
    endtask

    task automatic t_divisor();
        bit got, sok; logic [7:0] d0, d1; logic pb; int t0, t1;
        set_div(16'd2, 8'h03);
        check("R3", "divisor 2", divisor, 2);
        wr(3'd3, 8'h80);
        wr(3'd0, 8'h00);
        wr(3'd3, 8'h03);
        check("R3", "zero divisor ignored", divisor, 2);
        wr(3'd2, 8'h01);
        fork
            begin
                wr(3'd0, 8'h5A);
                wr(3'd0, 8'hC3);
            end
            begin
                rx_frame(2, 8, 0, 0, 100, got, d0, pb, sok, t0);
                rx_frame(2, 8, 0, 0, 100, got, d1, pb, sok, t1);
            end
        join
        check("R3", "div2 first byte", d0, 8'h5A);
        check("R3", "div2 second byte", d1, 8'hC3);
        check("R8", "character spacing", t1 - t0, 320);
        wait_temt();
        set_div(16'd1, 8'h03);
    endtask

    task automatic t_fifo();
        bit got, sok; logic [7:0] d; logic pb; int t0;
        logic [7:0] last;
        int nrx = 0;
        int bad = 0;
        fork
            begin
                wr(3'd0, 8'h11);
                wr(3'd0, 8'h22);
                wr(3'd0, 8'h33);
            end
            rx_frame(1, 8, 0, 0, 50, got, d, pb, sok, t0);
        join
        check("R8", "fifo byte 1", d, 8'h11);
        check("R8", "thre with queue non-empty", thre, 0);
        rx_frame(1, 8, 0, 0, 50, got, d, pb, sok, t0);
        check("R8", "fifo byte 2", d, 8'h22);
        check("R8", "thre with one queued", thre, 0);
        rx_frame(1, 8, 0, 0, 50, got, d, pb, sok, t0);
        check("R8", "fifo byte 3", d, 8'h33);
        check("R8", "thre after last left queue", thre, 1);
        check("R8", "temt during last frame", temt, 0);
        wait_temt();
        last = '0;
        fork
            for (int i = 0; i < 18; i++) wr(3'd0, 8'(i));
            for (int k = 0; k < 17; k++) begin
                rx_frame(1, 8, 0, 0, 50, got, d, pb, sok, t0);
                if (got) begin
                    nrx++;
                    if (d != 8'(k)) bad++;
                    last = d;
                end
            end
        join
        check("R8", "frames from full queue", nrx, 17);
        check("R8", "order mismatches", bad, 0);
        check("R8", "last accepted byte", last, 16);
        rx_frame(1, 8, 0, 0, 300, got, d, pb, sok, t0);
        check("R8", "byte written when full dropped", got, 0);
    endtask

    task automatic t_flush();
        bit got, sok; logic [7:0] d; logic pb; int t0;
        fork
            begin
                for (int i = 0; i < 4; i++) wr(3'd0, 8'hA0 + 8'(i));
                wr(3'd2, 8'h05);
                check("R10", "thre after flush", thre, 1);
            end
            rx_frame(1, 8, 0, 0, 50, got, d, pb, sok, t0);
        join
        check("R10", "frame in flight completes", d, 8'hA0);
        rx_frame(1, 8, 0, 0, 300, got, d, pb, sok, t0);
        check("R10", "no frame after flush", got, 0);
        check("R10", "temt after flush", temt, 1);
        wr(3'd2, 8'h00);
    endtask

    task automatic t_loop();
        int lows = 0;
        bit seen = 1'b0;
        logic [7:0] cap = '0;
        wr(3'd4, 8'h18);
        wr(3'd0, 8'h3C);
        for (int i = 0; i < 200; i++) begin
            @(negedge clk);
            if (serial_out !== 1'b1) lows++;
            if (lb_valid === 1'b1) begin
                seen = 1'b1;
                cap = lb_data;
            end
        end
        check("R11", "line held high", lows, 0);
        check("R11", "lb_valid seen", seen, 1);
        check("R11", "lb_data", cap, 8'h3C);
        wr(3'd3, 8'h01);
        seen = 1'b0;
        wr(3'd0, 8'hFF);
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            if (lb_valid === 1'b1) begin
                seen = 1'b1;
                cap = lb_data;
            end
        end
        check("R11", "6-bit lb_data masked", cap, 8'h3F);
        wait_temt();
        wr(3'd4, 8'h08);
        wr(3'd3, 8'h03);
    endtask

    task automatic t_break();
        int highs = 0;
        wr(3'd3, 8'h43);
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            if (serial_out !== 1'b0) highs++;
        end
        check("R12", "break holds line low", highs, 0);
        wr(3'd3, 8'h03);
        check("R12", "line released", serial_out, 1);
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_regs();
        t_format();
        t_parity();
        t_status();
        t_overwrite();
        t_divisor();
        t_fifo();
        t_flush();
        t_loop();
        t_break();
        finish_run();
    end
endmodule